// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase/Frequency Detector

This block is the digital heart of a fixed-ratio frequency multiplier. A reference clock passes through a fixed divide-by-8 stage. The oscillator clock that is fed back also passes through a fixed divide-by-8 stage, and then through a programmable divider. A static 4-bit code sets the programmable ratio N to 25 plus the unsigned code value. The total feedback division is therefore 8·N. When the loop is locked, the oscillator runs at N times the reference.

The two divided signals are single-cycle pulses in their own clock domains. Each one is turned into a toggle, and the toggle is synchronised into a fast system clock domain, where a two-flop phase/frequency detector compares the two. The detector has three outputs. An UP request sources charge. A DOWN request sinks charge. An enable tells the external charge pump to drive; when the enable is low, the pump is off (high impedance). A clear input freezes both divider chains and forces the detector off. Two monitor outputs let an observer see the detector inputs at half rate: each monitor toggles once per divided pulse on its path.

The charge pump, loop filter, oscillator and crystal circuit are outside this block.

Top module: `synth_div_pfd`

## Requirements
- R1: The programmable ratio is N = 25 + `code_i`, where `code_i[0]` is the least significant bit and `code_i[3]` the most significant. All ones selects 40. `mon_fb_o` completes one full period every 16·N rising edges of `vco_clk`.
- R2: The reference path divides by exactly 8. `mon_ref_o` completes one full period every 16 rising edges of `ref_clk`.
- R3: Each monitor output resets to 0. It toggles exactly once per divided pulse on its own path, so each monitor is a divide-by-2 copy of that detector input.
- R4: `code_i` is taken only when the programmable counter reloads. After a code change, every divider period is a whole 8·N_old or a whole 8·N_new oscillator cycles, and no shorter pulse ever appears.
- R5: While `clear_i` is 1, both divider chains are held cleared, both monitors stay at 0, and `up_o`, `dn_o` and `cp_en_o` are all 0. When `clear_i` returns to 0, division resumes at the programmed ratio.
- R6: A reference event sets `up_o` and a feedback event sets `dn_o`. Once both are set, both clear on the next system clock. They are never both 1 for more than one system cycle in a row.
- R7: When the divided reference is faster than the divided feedback, `up_o` is high for more system cycles than `dn_o`. When the feedback is faster, the reverse holds.
- R8: `cp_en_o` is 1 exactly when `up_o` or `dn_o` is 1. A 0 on `cp_en_o` means the pump output is off.
- R9: While `rst_n` is 0, every output is 0. Release of `rst_n` is synchronised in each clock domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Fast clock for the synchroniser back ends and the detector |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator (feedback) clock |
| clear_i | input | 1 | Active-high clear: holds the dividers and switches the detector off |
| code_i | input | 4 | Ratio code, N = 25 + code |
| up_o | output | 1 | Source request to the charge pump |
| dn_o | output | 1 | Sink request to the charge pump |
| cp_en_o | output | 1 | Pump drive enable (0 = high impedance) |
| mon_ref_o | output | 1 | Half-rate monitor of the divided reference |
| mon_fb_o | output | 1 | Half-rate monitor of the divided feedback |

## Verification
A wrong count in either prescaler or in the programmable counter changes the monitor period. The error is visible within one monitor period: 16·N oscillator cycles, or 16 reference cycles. The bench measures that period exactly for every code. A detector flop that sticks or fails to clear shows up within a few system cycles, either as UP and DOWN overlapping for more than one cycle or as the wrong side dominating when the two frequencies are deliberately mismatched. A clear that does not reach some domain shows up at once as a monitor that keeps toggling, or as a pump enable that stays on while the clear is high.

// File: rtl/synth_pkg.sv
`timescale 1ns/1ps
package synth_pkg;
  localparam int CODE_BITS   = 4;
  localparam int RATIO_BASE  = 25;
  localparam int PRESC_RATIO = 8;
  localparam int SYNC_DEPTH  = 2;

  // Detector drive state: bit0 = source request, bit1 = sink request
  typedef enum logic [1:0] {
    CP_OFF    = 2'b00,
    CP_SOURCE = 2'b01,
    CP_SINK   = 2'b10,
    CP_BOTH   = 2'b11
  } cp_state_e;
endpackage

// File: rtl/synth_rst_sync.sv
`timescale 1ns/1ps
module synth_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/synth_prescaler.sv
`timescale 1ns/1ps
module synth_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         tick_q, tick_d;
  logic         wrap;

  always_comb begin
    wrap   = (cnt_q == LAST);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R2
endmodule

// File: rtl/synth_prog_div.sv
`timescale 1ns/1ps
module synth_prog_div #(
  parameter int CODE_W = 4,
  parameter int BASE_N = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);
  localparam int MAX_N = BASE_N + (1 << CODE_W) - 1;
  localparam int CNT_W = $clog2(MAX_N + 1);
  localparam logic [CNT_W-1:0] BASE_C = CNT_W'(BASE_N);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_N);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] ratio_q, ratio_d;
  logic             pulse_q, pulse_d;
  logic             reload;
  logic [CNT_W-1:0] ratio_new;

  always_comb begin
    ratio_new = BASE_C + CNT_W'(code_i);
    reload    = tick_i && (cnt_q == '0);
    cnt_d     = cnt_q;
    ratio_d   = ratio_q;
    pulse_d   = reload;
    if (tick_i) begin
      if (reload) begin
        cnt_d   = ratio_new - 1'b1;
        ratio_d = ratio_new;
      end else begin
        cnt_d   = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= MAX_C;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q); // R4
  AST_RATIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q >= BASE_C) && (ratio_q <= MAX_C)); // R1
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q) && $stable(ratio_q)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R1
endmodule

// File: rtl/synth_pulse_xfer.sv
`timescale 1ns/1ps
module synth_pulse_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic pulse_i,
  output logic mon_o,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic evt_o
);
  logic            tog_q, tog_d;
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    tog_d = pulse_i ? ~tog_q : tog_q;
    sh_d  = {sh_q[STAGES-1:0], tog_q};
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sh_q <= '0;
    else            sh_q <= sh_d;
  end

  assign mon_o = tog_q;
  assign evt_o = sh_q[STAGES] ^ sh_q[STAGES-1];

  AST_EVT_SINGLE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    evt_o |=> !evt_o); // R3
  AST_MON_FOLLOWS: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    pulse_i |=> (mon_o != $past(mon_o))); // R3
endmodule

// File: rtl/synth_pfd.sv
`timescale 1ns/1ps
module synth_pfd
  import synth_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_evt_i,
  input  logic fb_evt_i,
  output logic up_o,
  output logic dn_o,
  output logic cp_en_o
);
  logic      up_q, up_d, dn_q, dn_d;
  logic      both;
  cp_state_e state;

  always_comb begin
    both = up_q & dn_q;
    up_d = (up_q & ~both) | ref_evt_i;
    dn_d = (dn_q & ~both) | fb_evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign state   = cp_state_e'({dn_q, up_q});
  assign up_o    = up_q;
  assign dn_o    = dn_q;
  assign cp_en_o = (state != CP_OFF);

  AST_OVERLAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> !(up_q && dn_q)); // R6
  AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt_i |=> up_q); // R6
  AST_DN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fb_evt_i |=> dn_q); // R6
endmodule

// File: rtl/synth_div_pfd.sv
`timescale 1ns/1ps
module synth_div_pfd
  import synth_pkg::*;
#(
  parameter int CODE_W      = CODE_BITS,
  parameter int BASE_N      = RATIO_BASE,
  parameter int PRESC_DIV   = PRESC_RATIO,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              vco_clk,
  input  logic              clear_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              up_o,
  output logic              dn_o,
  output logic              cp_en_o,
  output logic              mon_ref_o,
  output logic              mon_fb_o
);
  localparam int NPATH    = 2;
  localparam int PATH_REF = 0;
  localparam int PATH_FB  = 1;

  logic             arst_n;
  logic             sys_rst_n;
  logic [NPATH-1:0] path_clk;
  logic [NPATH-1:0] path_rst_n;
  logic [NPATH-1:0] path_tick;
  logic [NPATH-1:0] path_pulse;
  logic [NPATH-1:0] path_mon;
  logic [NPATH-1:0] path_evt;

  assign arst_n   = rst_n & ~clear_i;
  assign path_clk = {vco_clk, ref_clk};

  synth_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(sys_clk), .arst_n(arst_n), .rst_n_o(sys_rst_n)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    synth_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk(path_clk[p]), .arst_n(arst_n), .rst_n_o(path_rst_n[p])
    );

    synth_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk(path_clk[p]), .rst_n(path_rst_n[p]), .tick_o(path_tick[p])
    );

    if (p == PATH_FB) begin : g_prog
      synth_prog_div #(.CODE_W(CODE_W), .BASE_N(BASE_N)) u_div (
        .clk(path_clk[p]), .rst_n(path_rst_n[p]), .tick_i(path_tick[p]),
        .code_i(code_i), .pulse_o(path_pulse[p])
      );
    end else begin : g_direct
      assign path_pulse[p] = path_tick[p];
    end

    synth_pulse_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
      .src_clk(path_clk[p]), .src_rst_n(path_rst_n[p]), .pulse_i(path_pulse[p]),
      .mon_o(path_mon[p]), .dst_clk(sys_clk), .dst_rst_n(sys_rst_n),
      .evt_o(path_evt[p])
    );
  end

  synth_pfd u_pfd (
    .clk(sys_clk), .rst_n(sys_rst_n),
    .ref_evt_i(path_evt[PATH_REF]), .fb_evt_i(path_evt[PATH_FB]),
    .up_o(up_o), .dn_o(dn_o), .cp_en_o(cp_en_o)
  );

  assign mon_ref_o = path_mon[PATH_REF];
  assign mon_fb_o  = path_mon[PATH_FB];

  AST_CLEAR_OFF: assert property (@(posedge sys_clk) disable iff (!rst_n)
    clear_i |-> (!cp_en_o && !up_o && !dn_o)); // R5
  AST_EN_MATCH: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cp_en_o == (up_o || dn_o)); // R8
  AST_RESET_IDLE: assert property (@(posedge sys_clk)
    !rst_n |-> (!up_o && !dn_o && !mon_fb_o && !mon_ref_o)); // R9
endmodule

// File: tb/tb_synth_div_pfd.sv
`timescale 1ns/1ps
module tb_synth_div_pfd;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [3:0]  code;
    logic [15:0] exp_cycles;
  } vec_t;

  // code -> oscillator cycles per monitor period, 16*(25+code)
  localparam vec_t VECS [16] = '{
    '{4'd0, 16'd400},  '{4'd15, 16'd640}, '{4'd1, 16'd416},  '{4'd14, 16'd624},
    '{4'd2, 16'd432},  '{4'd13, 16'd608}, '{4'd3, 16'd448},  '{4'd12, 16'd592},
    '{4'd4, 16'd464},  '{4'd11, 16'd576}, '{4'd5, 16'd480},  '{4'd10, 16'd560},
    '{4'd6, 16'd496},  '{4'd9, 16'd544},  '{4'd7, 16'd512},  '{4'd8, 16'd528}
  };

  logic       sys_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic       rst_n;
  logic       clear_i;
  logic [3:0] code_i;
  logic       up_o, dn_o, cp_en_o, mon_ref_o, mon_fb_o;

  int ref_half = 20;
  int vco_half = 1;
  int unsigned vco_cnt = 0;
  int unsigned ref_cnt = 0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  synth_div_pfd dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk),
    .clear_i(clear_i), .code_i(code_i), .up_o(up_o), .dn_o(dn_o),
    .cp_en_o(cp_en_o), .mon_ref_o(mon_ref_o), .mon_fb_o(mon_fb_o)
  );

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;
  always #(ref_half) ref_clk = ~ref_clk;
  always #(vco_half) vco_clk = ~vco_clk;
  always @(posedge vco_clk) vco_cnt = vco_cnt + 1;
  always @(posedge ref_clk) ref_cnt = ref_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure_fb(output int unsigned d);
    int unsigned t0;
    @(posedge mon_fb_o);
    t0 = vco_cnt;
    @(posedge mon_fb_o);
    d = vco_cnt - t0;
  endtask

  task automatic measure_ref(output int unsigned d);
    int unsigned t0;
    @(posedge mon_ref_o);
    t0 = ref_cnt;
    @(posedge mon_ref_o);
    d = ref_cnt - t0;
  endtask

  // Counts cycles with up/dn high, the longest overlap run and enable mismatches
  task automatic pfd_window(input int cycles, output int ups, output int dns,
                            output int max_run, output int en_bad);
    int run;
    ups = 0; dns = 0; max_run = 0; en_bad = 0; run = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge sys_clk);
      if (up_o) ups++;
      if (dn_o) dns++;
      if (cp_en_o != (up_o | dn_o)) en_bad++;
      if (up_o && dn_o) run++; else run = 0;
      if (run > max_run) max_run = run;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned d;
    int ups, dns, mrun, ebad, mon_hi;
    rst_n = 1'b0; clear_i = 1'b0; code_i = 4'd0;
    repeat (5) @(negedge sys_clk);
    // R9: outputs idle while reset is held
    chk(!up_o && !dn_o && !cp_en_o, "R9 pfd idle in reset", {up_o, dn_o, cp_en_o}, 0);
    chk(!mon_fb_o && !mon_ref_o, "R9 monitors idle in reset", {mon_fb_o, mon_ref_o}, 0);
    rst_n = 1'b1;
    @(negedge sys_clk);
    chk(!mon_fb_o && !mon_ref_o, "R3 monitors start at zero", {mon_fb_o, mon_ref_o}, 0);

    // R1: table of codes, each measured after settling
    foreach (VECS[i]) begin
      code_i = VECS[i].code;
      measure_fb(d);
      measure_fb(d);
      measure_fb(d);
      chk(d == VECS[i].exp_cycles, $sformatf("R1 code %0d ratio", VECS[i].code),
          d, VECS[i].exp_cycles);
    end

    // R2, R3: reference path half-rate monitor period
    measure_ref(d);
    chk(d == 16, "R2 reference /8 monitor period", d, 16);

    // R4: code change mid-period gives only whole periods
    code_i = 4'd0;
    measure_fb(d); measure_fb(d);
    repeat (150) @(posedge vco_clk);
    code_i = 4'd15;
    for (int k = 0; k < 3; k++) begin
      measure_fb(d);
      chk(d == 400 || d == 520 || d == 640, "R4 no runt after code change", d, 520);
    end
    chk(d == 640, "R4 new code in effect", d, 640);

    // R7, R6, R8: reference faster than feedback (code 0: fb 400ns, ref 320ns)
    code_i = 4'd0;
    measure_fb(d); measure_fb(d);
    pfd_window(3000, ups, dns, mrun, ebad);
    chk(ups > dns, "R7 up dominates when reference faster", ups, dns);
    chk(mrun <= 1, "R6 overlap at most one cycle (ref fast)", mrun, 1);
    chk(ebad == 0, "R8 enable tracks up/dn (ref fast)", ebad, 0);

    // R7: feedback faster (ref event period 640ns)
    ref_half = 40;
    repeat (200) @(negedge sys_clk);
    pfd_window(3000, ups, dns, mrun, ebad);
    chk(dns > ups, "R7 dn dominates when feedback faster", dns, ups);
    chk(mrun <= 1, "R6 overlap at most one cycle (fb fast)", mrun, 1);
    chk(ebad == 0, "R8 enable tracks up/dn (fb fast)", ebad, 0);

    // R5: clear freezes dividers and switches detector off
    code_i = 4'd15;
    @(negedge sys_clk);
    clear_i = 1'b1;
    @(negedge sys_clk);
    chk(!up_o && !dn_o && !cp_en_o, "R5 detector off under clear",
        {up_o, dn_o, cp_en_o}, 0);
    mon_hi = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge vco_clk);
      if (mon_fb_o || mon_ref_o) mon_hi++;
    end
    chk(mon_hi == 0, "R5 monitors held during clear", mon_hi, 0);
    pfd_window(50, ups, dns, mrun, ebad);
    chk(ups == 0 && dns == 0, "R5 no up/dn during clear", ups + dns, 0);
    clear_i = 1'b0;
    measure_fb(d);
    chk(d == 640, "R5 ratio resumes after clear", d, 640);
    measure_ref(d);
    chk(d == 16, "R5 reference resumes after clear", d, 16);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule